// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Flow Control

This block turns characters written from a CPU-side port into an asynchronous serial stream. Each frame starts with a low start bit. The data bits follow least-significant first, then an optional parity bit, then one or two high stop bits. A single holding register sits in front of the shift register, so software can queue one character while the previous one is still going out. Commands enable, disable and reset the transmitter, and start or stop a break condition. A request-to-send output can be set and cleared by command, and in automatic mode it drops by itself once a message has drained after a disable.

Transmission can be gated by an active-low clear-to-send input. A one-cycle bit-clock enable paces every bit; the bit rate is generated elsewhere. The ready and empty outputs let software or an interrupt controller decide when to write the next character.

Top module: `uart_tx_fc`

## Requirements
- R1: After `rst_n` is low, `txd` is 1, `tx_ready` is 0, `tx_empty` is 1 and `rts` is 0. The transmitter stays disabled until `cmd_enable` is pulsed.
- R2: The frame is laid out as follows. A 0 start bit comes first. Then come 5 + `cfg_len` data bits (`cfg_len` 0..3 selects 5..8), least-significant first. If `cfg_par_en` is 1, a parity bit follows: it equals the XOR of the sent data bits when `cfg_par_odd` is 0, and the inverse of that XOR when `cfg_par_odd` is 1. Last come one stop bit of 1, or two when `cfg_stop2` is 1. Each bit lasts one `bit_en` period and changes in the cycle after a `bit_en` pulse.
- R3: Bits of `wr_data` above the selected character length are not sent.
- R4: `tx_ready` is 1 exactly when the transmitter is enabled and the holding register is free, and a write with `tx_ready` high is taken. On the `bit_en` pulse at which the shift register is idle or has finished its last bit, the held character moves into the shift register and `tx_ready` rises again. Back-to-back characters leave no idle gap. `tx_empty` is 1 only when both registers are empty, and `txd` is 1 then.
- R5: A write while the transmitter is disabled is refused. It is never sent, even after a later enable.
- R6: After `cmd_disable`, the character in the shift register completes. With `cfg_auto_rts` at 0, a held character is kept unsent (so `tx_empty` stays 0) and goes out after `cmd_enable`.
- R7: With `cfg_cts_en` at 1, a character starts only while `cts_n` is 0. If `cts_n` rises mid-character, that character completes and `txd` then stays 1 until `cts_n` falls.
- R8: After `cmd_brk_on`, once no character is pending, or the only pending one is blocked by clear-to-send, `txd` is held at 0 regardless of `cts_n`. Characters already in the shift or holding register are sent first. The break ends only on `cmd_brk_off`, `cmd_disable` or `cmd_reset`, and a character written during the break goes out afterwards.
- R9: `cmd_reset` takes effect on the next clock edge. It stops the frame in progress, drives `txd` to 1 and discards the held character. The transmitter is left disabled.
- R10: `cmd_rts_set` sets `rts` and `cmd_rts_clr` clears it. With `cfg_auto_rts` at 1, a held character is still sent after a disable, and `rts` is cleared once the transmitter is disabled and both registers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per bit period |
| cfg_len | input | 2 | Character length minus five |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_cts_en | input | 1 | Gate character starts on `cts_n` |
| cfg_auto_rts | input | 1 | Clear `rts` automatically after a disable drains |
| cmd_enable | input | 1 | Enable pulse |
| cmd_disable | input | 1 | Disable pulse |
| cmd_reset | input | 1 | Transmitter reset pulse |
| cmd_brk_on | input | 1 | Start-break pulse |
| cmd_brk_off | input | 1 | Stop-break pulse |
| cmd_rts_set | input | 1 | Assert request-to-send |
| cmd_rts_clr | input | 1 | Negate request-to-send |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial output, idle high |
| rts | output | 1 | Request-to-send, 1 = asserted |
| tx_ready | output | 1 | Holding register can take a write |
| tx_empty | output | 1 | Both registers empty |

## Verification
A write changes `tx_ready` and `tx_empty` one cycle later, and a command changes the flags and `rts` one cycle later. A frame begins on the cycle after the first `bit_en` pulse that finds the shift register free, and each later bit appears on the cycle after the next pulse. The bench drives stimulus on falling clock edges, so the flags are read at the falling edge after a one-cycle pulse. The serial receiver in the bench waits for the falling start edge. It then samples each bit one and a half clocks into its period and every `bit_en` period after that, well clear of the bit boundaries. Conditions that must hold over time, such as a stalled or discarded character, are checked by watching `txd` on every falling edge across a window longer than a whole frame.

// File: rtl/uart_tx_fc.sv
module uart_tx_fc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_cts_en,
  input  logic       cfg_auto_rts,
  input  logic       cmd_enable,
  input  logic       cmd_disable,
  input  logic       cmd_reset,
  input  logic       cmd_brk_on,
  input  logic       cmd_brk_off,
  input  logic       cmd_rts_set,
  input  logic       cmd_rts_clr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cts_n,
  output logic       txd,
  output logic       rts,
  output logic       tx_ready,
  output logic       tx_empty
);
  localparam int SW = 11;

  logic          en_r, hold_v, busy, brk_req, brk_on, txd_r;
  logic [7:0]    hold_d;
  logic [SW-1:0] sh;
  logic [3:0]    cnt;

  wire [3:0]    dlen      = 4'd5 + {2'b00, cfg_len};
  wire [7:0]    dmask     = hold_d & (8'hFF >> (2'd3 - cfg_len));
  wire          pbit      = cfg_par_en ? (^dmask ^ cfg_par_odd) : 1'b1;
  wire [SW-1:0] frame_c   = {3'b000, dmask} | ({10'h3FF, pbit} << dlen);
  wire [3:0]    nrem      = dlen + {3'b000, cfg_par_en} + 4'd1 + {3'b000, cfg_stop2};
  wire          cts_block = cfg_cts_en & cts_n;
  wire          sendable  = hold_v & (en_r | cfg_auto_rts) & ~cts_block;
  wire          start_ok  = sendable & ~brk_on;

  assign tx_ready = en_r & ~hold_v;
  assign tx_empty = ~hold_v & ~busy;
  assign txd      = txd_r & ~brk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= 1'b0; hold_v <= 1'b0; busy <= 1'b0; brk_req <= 1'b0; brk_on <= 1'b0;
      txd_r <= 1'b1; hold_d <= '0; sh <= '1; cnt <= '0;
    end else if (cmd_reset) begin
      en_r <= 1'b0; hold_v <= 1'b0; busy <= 1'b0; brk_req <= 1'b0; brk_on <= 1'b0;
      txd_r <= 1'b1; cnt <= '0;
    end else begin
      if (tx_ready && wr_en) begin
        hold_v <= 1'b1;
        hold_d <= wr_data;
      end
      if (bit_en) begin
        if (busy && cnt != 4'd0) begin
          txd_r <= sh[0];
          sh    <= {1'b1, sh[SW-1:1]};
          cnt   <= cnt - 4'd1;
        end else if (start_ok) begin
          busy   <= 1'b1;
          txd_r  <= 1'b0;
          sh     <= frame_c;
          cnt    <= nrem;
          hold_v <= 1'b0;
        end else begin
          busy  <= 1'b0;
          txd_r <= 1'b1;
          if (brk_req && !sendable) brk_on <= 1'b1;
        end
      end
      if (cmd_enable) en_r <= 1'b1;
      if (cmd_brk_on && en_r) brk_req <= 1'b1;
      if (cmd_brk_off || cmd_disable) begin
        brk_req <= 1'b0;
        brk_on  <= 1'b0;
      end
      if (cmd_disable) en_r <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts <= 1'b0;
    else if (cfg_auto_rts && !en_r && !hold_v && !busy) rts <= 1'b0;
    else if (cmd_rts_clr) rts <= 1'b0;
    else if (cmd_rts_set) rts <= 1'b1;
  end
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic cfg_cts_en,
  input logic cfg_auto_rts,
  input logic cts_n,
  input logic cmd_reset,
  input logic wr_en,
  input logic txd,
  input logic rts,
  input logic tx_ready,
  input logic tx_empty,
  input logic en_r,
  input logic busy,
  input logic brk_req,
  input logic brk_on
);
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && wr_en |=> !tx_ready);

  a_r4_empty_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && !brk_on |-> txd);

  a_r5_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready && tx_empty |=> tx_empty);

  a_r7_cts_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && cfg_cts_en && cts_n && !busy && !brk_req && !brk_on |=> txd);

  a_r9_reset_now: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> txd && tx_empty && !tx_ready);

  a_r10_auto_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_auto_rts && !en_r && tx_empty |=> !rts);
endmodule

bind uart_tx_fc uart_tx_fc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_cts_en(cfg_cts_en),
  .cfg_auto_rts(cfg_auto_rts), .cts_n(cts_n), .cmd_reset(cmd_reset), .wr_en(wr_en),
  .txd(txd), .rts(rts), .tx_ready(tx_ready), .tx_empty(tx_empty), .en_r(en_r),
  .busy(busy), .brk_req(brk_req), .brk_on(brk_on)
);

// File: tb/sim_uart_tx_fc.sv
module sim_uart_tx_fc;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam logic [6:0] C_EN = 7'h01, C_DIS = 7'h02, C_RST = 7'h04, C_BON = 7'h08,
                         C_BOFF = 7'h10, C_RSET = 7'h20, C_RCLR = 7'h40;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic cfg_cts_en = 1'b0, cfg_auto_rts = 1'b0, cts_n = 1'b0;
  logic [6:0] cmds = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, rts, tx_ready, tx_empty;
  int n_chk = 0, n_bad = 0, divc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin
    divc   <= (divc == DIV-1) ? 0 : divc + 1;
    bit_en <= (divc == DIV-1);
  end

  uart_tx_fc u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_cts_en(cfg_cts_en),
    .cfg_auto_rts(cfg_auto_rts), .cmd_enable(cmds[0]), .cmd_disable(cmds[1]),
    .cmd_reset(cmds[2]), .cmd_brk_on(cmds[3]), .cmd_brk_off(cmds[4]),
    .cmd_rts_set(cmds[5]), .cmd_rts_clr(cmds[6]), .wr_en(wr_en), .wr_data(wr_data),
    .cts_n(cts_n), .txd(txd), .rts(rts), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [6:0] m);
    @(negedge clk); cmds = m;
    @(negedge clk); cmds = '0;
  endtask

  task automatic put(input logic [7:0] d);
    int t = 0;
    @(negedge clk);
    while (!tx_ready && t < 400) begin @(negedge clk); t++; end
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic put_blind(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic int frame_len();
    return 1 + 5 + int'(cfg_len) + int'(cfg_par_en) + 1 + int'(cfg_stop2);
  endfunction

  function automatic logic [11:0] frame_exp(input logic [7:0] d);
    logic [11:0] f = '1;
    int nd = 5 + int'(cfg_len);
    int ones = 0;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (cfg_par_en) f[nd+1] = (ones % 2 == 1) ^ cfg_par_odd;
    return f;
  endfunction

  task automatic rx(input logic [7:0] d, input string tag);
    logic [11:0] got = '1;
    logic [11:0] exp = frame_exp(d);
    int nb = frame_len();
    int t = 0;
    while (txd !== 1'b0 && t < 600) begin @(negedge clk); t++; end
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      got[i] = txd;
      if (i < nb-1) repeat (DIV) @(negedge clk);
    end
    chk(got == exp, tag, int'(got), int'(exp));
  endtask

  task automatic stay(input int n, input logic lvl, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== lvl) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic drain();
    int t = 0;
    while (!tx_empty && t < 600) begin @(negedge clk); t++; end
    repeat (DIV+1) @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'hE3, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1 && !tx_ready && tx_empty && !rts, "R1 idle",
        {txd, tx_ready, tx_empty, rts}, 4'b1010);
    cmd(C_EN);
    chk(tx_ready === 1'b1, "R4 ready after enable", tx_ready, 1);

    // R2/R3 sweep over length, parity and stop configurations
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++)
          foreach (pats[k]) begin
            drain();
            cfg_len = 2'(l); cfg_par_en = (p != 0); cfg_par_odd = (p == 2); cfg_stop2 = s[0];
            put(pats[k]);
            rx(pats[k], "R2/R3 frame");
          end
    drain();
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;

    // R4 flags and back-to-back
    put(8'h55);
    chk(!tx_ready && !tx_empty, "R4 flags after write", {tx_ready, tx_empty}, 0);
    fork
      begin rx(8'h55, "R4 first"); rx(8'h96, "R4 back-to-back"); end
      begin
        while (txd !== 1'b0) @(negedge clk);
        chk(tx_ready && !tx_empty, "R4 ready after transfer", {tx_ready, tx_empty}, 2);
        put(8'h96);
      end
    join
    repeat (DIV+1) @(negedge clk);
    chk(tx_empty && txd, "R4 empty after last", {tx_empty, txd}, 3);

    // R5 refused writes
    cmd(C_DIS);
    put_blind(8'h0F);
    chk(tx_empty === 1'b1, "R5 refused write", tx_empty, 1);
    stay(40, 1'b1, "R5 no output while disabled");
    cmd(C_EN);
    stay(60, 1'b1, "R5 refused char never sent");

    // R6 disable keeps held character
    fork
      rx(8'hC3, "R6 current completes");
      begin put(8'hC3); put(8'h1E); cmd(C_DIS); end
    join
    stay(60, 1'b1, "R6 held not sent");
    chk(!tx_empty && !tx_ready, "R6 held kept", {tx_empty, tx_ready}, 0);
    cmd(C_EN);
    rx(8'h1E, "R6 held sent after enable");
    drain();

    // R7 clear-to-send
    cfg_cts_en = 1'b1; cts_n = 1'b1;
    put(8'h81);
    stay(40, 1'b1, "R7 blocked start");
    cts_n = 1'b0;
    rx(8'h81, "R7 sent after clear");
    drain();
    fork
      rx(8'h42, "R7 mid-character completes");
      begin put(8'h42); put(8'h24); repeat (8) @(negedge clk); cts_n = 1'b1; end
    join
    stay(60, 1'b1, "R7 mark while blocked");
    chk(!tx_empty, "R7 next held", tx_empty, 0);
    cts_n = 1'b0;
    rx(8'h24, "R7 resumes");
    drain();
    cfg_cts_en = 1'b0;

    // R8 break
    cmd(C_BON);
    repeat (DIV+1) @(negedge clk);
    cfg_cts_en = 1'b1; cts_n = 1'b1;
    put(8'h77);
    stay(40, 1'b0, "R8 break held low");
    cfg_cts_en = 1'b0; cts_n = 1'b0;
    cmd(C_BOFF);
    rx(8'h77, "R8 char after stop-break");
    drain();
    fork
      begin rx(8'h5A, "R8 pending first"); rx(8'hA9, "R8 pending second"); end
      begin put(8'h5A); put(8'hA9); cmd(C_BON); end
    join
    repeat (DIV+2) @(negedge clk);
    chk(txd === 1'b0, "R8 deferred break", txd, 0);
    cmd(C_DIS);
    chk(txd === 1'b1, "R8 disable ends break", txd, 1);
    cmd(C_EN);
    cfg_cts_en = 1'b1; cts_n = 1'b1;
    put(8'h3A);
    cmd(C_BON);
    stay(12, 1'b0, "R8 break over blocked char");
    cmd(C_BOFF);
    stay(20, 1'b1, "R8 blocked after stop-break");
    cts_n = 1'b0;
    rx(8'h3A, "R8 blocked char later sent");
    drain();
    cfg_cts_en = 1'b0;

    // R9 reset command
    put(8'hF0);
    while (txd !== 1'b0) @(negedge clk);
    put(8'h0F);
    repeat (8) @(negedge clk);
    cmd(C_RST);
    chk(txd && tx_empty && !tx_ready, "R9 reset immediate",
        {txd, tx_empty, tx_ready}, 6);
    cmd(C_EN);
    stay(60, 1'b1, "R9 held discarded");

    // R10 request-to-send
    cmd(C_RSET);
    chk(rts === 1'b1, "R10 set", rts, 1);
    cmd(C_RCLR);
    chk(rts === 1'b0, "R10 clear", rts, 0);
    cfg_auto_rts = 1'b1;
    cmd(C_RSET);
    fork
      begin rx(8'hB4, "R10 first"); rx(8'h4B, "R10 held sent despite disable"); end
      begin
        put(8'hB4); put(8'h4B); cmd(C_DIS);
        chk(rts === 1'b1, "R10 kept while draining", rts, 1);
        put_blind(8'hEE);
      end
    join
    repeat (DIV+2) @(negedge clk);
    chk(rts === 1'b0 && tx_empty, "R10 auto drop", {rts, tx_empty}, 1);
    cmd(C_EN);
    stay(60, 1'b1, "R10 write after disable refused");
    cfg_auto_rts = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule